// File: doc/BRIEF.md
# Timer Compare CSR Access Gate

This block sits beside the CSR decoder and rules on every access to the addresses of the supervisor timer compare register and of its virtual counterpart. From the current privilege level, the virtualization flag, the CSR address and two levels of control bits, it gives one of three verdicts: the access proceeds, it raises an illegal-instruction exception, or it raises a virtual-instruction exception.

The control bits come in two pairs. The first pair is the time bits of the machine and hypervisor counter-enable registers, which are inputs to this block. The second pair is the timer-compare enable bits of the machine and hypervisor environment-config registers. This block holds those two enable bits itself. It takes writes to them and returns their read values.

When an allowed access from the virtual supervisor level names the supervisor compare address, a redirect flag tells the register file to use the virtual compare register instead. The `XLEN` parameter places the enable bit and decides whether the high-half addresses exist. The `EXT_EN` parameter ties both enable bits to zero when the feature is left out.

Top module: `tcmp_access_gate`

## Requirements
- R1: With priv 2'b11 (machine), every access to a timer compare address is allowed, whatever the enable and counter bits hold.
- R2: Below machine level (priv 2'b01 supervisor, any other code user), a clear machine counter-enable time bit gives illegal.
- R3: Below machine level, a machine enable bit that reads 0 gives illegal.
- R4: With virt_mode=1 and both machine conditions met, a clear hypervisor counter-enable time bit gives a virtual fault.
- R5: With virt_mode=1 and both machine conditions met, a hypervisor enable bit that reads 0 gives a virtual fault.
- R6: When an illegal condition and a virtual-fault condition hold together, the result is illegal.
- R7: acc_redirect is 1 only for an allowed access to supervisor address 0x14D (or 0x15D) with virt_mode=1. It is 0 for direct accesses to 0x24D from the non-virtual supervisor level.
- R8: For addresses 0x14D and 0x24D (plus 0x15D and 0x25D when XLEN=32), exactly one of acc_ok, acc_illegal and acc_virt is 1. For every other address, all four outputs are 0.
- R9: A non-virtual user access gives illegal. With the machine conditions met, a virtual user access gives a virtual fault, and so does a virtual supervisor access to 0x24D.
- R10: Both enable bits reset to 0. A write loads bit XLEN-1 of cfg_wdata (bit 63 by default), ignores all other bits, and shows on the read port from the cycle after the write edge.
- R11: henv_tce reads 0 while the machine bit is 0. Hypervisor writes are ignored while the machine bit is 0. The stored hypervisor value reappears once the machine bit is set again.
- R12: With XLEN=64, addresses 0x15D and 0x25D are unrelated addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Privilege: 11 machine, 01 supervisor, other user |
| virt_mode | input | 1 | Virtualization flag |
| csr_addr | input | 12 | CSR address of the access |
| mcen_tm | input | 1 | Machine counter-enable time bit |
| hcen_tm | input | 1 | Hypervisor counter-enable time bit |
| cfg_m_we | input | 1 | Write strobe for the machine enable bit |
| cfg_h_we | input | 1 | Write strobe for the hypervisor enable bit |
| cfg_wdata | input | XLEN | Write data; only bit XLEN-1 is used |
| menv_tce | output | 1 | Read value of the machine enable bit |
| henv_tce | output | 1 | Read value of the hypervisor enable bit |
| acc_ok | output | 1 | Access allowed |
| acc_illegal | output | 1 | Illegal-instruction exception |
| acc_virt | output | 1 | Virtual-instruction exception |
| acc_redirect | output | 1 | Use the virtual compare register |

## Verification
The bench covers the priority corner, where the machine and hypervisor gates fail together. A design that ranked them the wrong way would report a virtual fault where an illegal exception is due. It also covers the neighbouring addresses 0x14C and 0x15D. A loose address decode would flag these, and a missing one would leave a real compare access unanswered. The enable bits are written with a decoy bit one place below the live bit, which exposes an off-by-one bit position. A hypervisor write made while the machine bit is clear shows whether the design ignores it or lets the stored value leak through.

// File: rtl/tcmp_access_gate.sv
module tcmp_access_gate #(
  parameter int XLEN   = 64,
  parameter bit EXT_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv_lvl,
  input  logic            virt_mode,
  input  logic [11:0]     csr_addr,
  input  logic            mcen_tm,
  input  logic            hcen_tm,
  input  logic            cfg_m_we,
  input  logic            cfg_h_we,
  input  logic [XLEN-1:0] cfg_wdata,
  output logic            menv_tce,
  output logic            henv_tce,
  output logic            acc_ok,
  output logic            acc_illegal,
  output logic            acc_virt,
  output logic            acc_redirect
);
  localparam int         TCE_BIT = XLEN - 1;
  localparam bit         HAS_HI  = (XLEN == 32);
  localparam logic [11:0] S_LO = 12'h14D, S_HI = 12'h15D;
  localparam logic [11:0] V_LO = 12'h24D, V_HI = 12'h25D;

  logic menv_q, henv_q;
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  generate
    if (EXT_EN) begin : g_tce
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          menv_q <= 1'b0;
          henv_q <= 1'b0;
        end else begin
          if (cfg_m_we) menv_q <= cfg_wdata[TCE_BIT];
          if (cfg_h_we && menv_q) henv_q <= cfg_wdata[TCE_BIT];
        end
      end
      AST_TCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_m_we |=> menv_tce == $past(cfg_wdata[TCE_BIT])); // R10
    end else begin : g_no_tce
      assign menv_q = 1'b0;
      assign henv_q = 1'b0;
    end
  endgenerate

  assign menv_tce = menv_q;
  assign henv_tce = henv_q & menv_q;

  logic is_s, is_v, hit, m_mode, s_lvl;
  logic mach_fail, user_fail, virt_cond;

  assign is_s   = (csr_addr == S_LO) || (HAS_HI && csr_addr == S_HI);
  assign is_v   = (csr_addr == V_LO) || (HAS_HI && csr_addr == V_HI);
  assign hit    = is_s | is_v;
  assign m_mode = (priv_lvl == 2'b11);
  assign s_lvl  = (priv_lvl == 2'b01);

  assign mach_fail = !m_mode && (!mcen_tm || !menv_tce);
  assign user_fail = !m_mode && !virt_mode && !s_lvl;
  assign virt_cond = !m_mode && virt_mode &&
                     (!hcen_tm || !henv_tce || !s_lvl || is_v);

  assign acc_illegal  = hit && (mach_fail || user_fail);
  assign acc_virt     = hit && !acc_illegal && virt_cond;
  assign acc_ok       = hit && !acc_illegal && !acc_virt;
  assign acc_redirect = acc_ok && is_s && virt_mode && !m_mode;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $countones({acc_ok, acc_illegal, acc_virt}) == 1); // R8
  AST_QUIET_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !(acc_ok || acc_illegal || acc_virt || acc_redirect)); // R8
  AST_MACH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && priv_lvl == 2'b11) |-> acc_ok); // R1
  AST_CEN_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && priv_lvl != 2'b11 && !mcen_tm) |-> acc_illegal); // R2
  AST_ENV_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && priv_lvl != 2'b11 && !menv_tce) |-> acc_illegal); // R3
  AST_ILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_mode && !mcen_tm) |-> !acc_virt); // R6
  AST_REDIR_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_redirect |-> (virt_mode && acc_ok)); // R7
  AST_HENV_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !menv_tce |-> !henv_tce); // R11
endmodule

// File: tb/sim_tcmp_access_gate.sv
module sim_tcmp_access_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] priv_lvl = 2'b11;
  logic virt_mode = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic mcen_tm = 1'b0, hcen_tm = 1'b0, cfg_m_we = 1'b0, cfg_h_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic menv_tce, henv_tce, acc_ok, acc_illegal, acc_virt, acc_redirect;
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tcmp_access_gate u0 (.*);

  // {priv[26:25], virt[24], addr[23:12], mcen, hcen, menv, henv, ok, ill, vf, redir, req[3:0]}
  localparam int NV = 17;
  localparam logic [26:0] VEC [NV] = '{
    {2'd3, 1'b0, 12'h14D, 4'b0000, 4'b1000, 4'd1},   // R1
    {2'd3, 1'b0, 12'h24D, 4'b0000, 4'b1000, 4'd1},   // R1
    {2'd1, 1'b0, 12'h14D, 4'b0010, 4'b0100, 4'd2},   // R2
    {2'd1, 1'b0, 12'h14D, 4'b1000, 4'b0100, 4'd3},   // R3
    {2'd1, 1'b0, 12'h14D, 4'b1010, 4'b1000, 4'd8},   // R8
    {2'd1, 1'b1, 12'h14D, 4'b1011, 4'b0010, 4'd4},   // R4
    {2'd1, 1'b1, 12'h14D, 4'b1110, 4'b0010, 4'd5},   // R5
    {2'd1, 1'b1, 12'h14D, 4'b0011, 4'b0100, 4'd6},   // R6
    {2'd1, 1'b1, 12'h14D, 4'b1000, 4'b0100, 4'd6},   // R6
    {2'd1, 1'b1, 12'h14D, 4'b1111, 4'b1001, 4'd7},   // R7
    {2'd1, 1'b0, 12'h24D, 4'b1111, 4'b1000, 4'd7},   // R7
    {2'd0, 1'b0, 12'h14D, 4'b1111, 4'b0100, 4'd9},   // R9
    {2'd0, 1'b1, 12'h14D, 4'b1111, 4'b0010, 4'd9},   // R9
    {2'd1, 1'b1, 12'h24D, 4'b1111, 4'b0010, 4'd9},   // R9
    {2'd1, 1'b0, 12'h15D, 4'b1111, 4'b0000, 4'd12},  // R12
    {2'd3, 1'b0, 12'h14C, 4'b1111, 4'b0000, 4'd8},   // R8
    {2'd1, 1'b1, 12'hC01, 4'b1111, 4'b0000, 4'd8}    // R8
  };

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic wr(input bit mach, input logic [63:0] d);
    @(negedge clk);
    cfg_wdata = d;
    cfg_m_we = mach;
    cfg_h_we = !mach;
    @(negedge clk);
    cfg_m_we = 1'b0;
    cfg_h_we = 1'b0;
  endtask

  function automatic logic [63:0] tb(input bit v);
    return {v, 63'd0};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    priv_lvl = 2'b01;
    csr_addr = 12'h14D;
    mcen_tm = 1'b1;
    #12;
    check("R10 reset env", {2'b00, menv_tce, henv_tce}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset S access", {acc_ok, acc_illegal, acc_virt, acc_redirect}, 4'b0100);

    wr(1'b1, 64'h4000_0000_0000_0000);
    check("R10 decoy bit 62", {3'b000, menv_tce}, 4'b0000);
    wr(1'b1, tb(1'b1));
    check("R10 bit 63 load", {3'b000, menv_tce}, 4'b0001);

    wr(1'b0, tb(1'b1));
    check("R11 henv set", {3'b000, henv_tce}, 4'b0001);
    wr(1'b1, tb(1'b0));
    check("R11 henv masked", {3'b000, henv_tce}, 4'b0000);
    wr(1'b0, tb(1'b0));
    wr(1'b1, tb(1'b1));
    check("R11 write ignored, value kept", {3'b000, henv_tce}, 4'b0001);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      wr(1'b1, tb(1'b1));
      wr(1'b0, tb(v[8]));
      wr(1'b1, tb(v[9]));
      @(negedge clk);
      priv_lvl = v[26:25];
      virt_mode = v[24];
      csr_addr = v[23:12];
      mcen_tm = v[11];
      hcen_tm = v[10];
      #2;
      check($sformatf("R%0d vec%0d", v[3:0], i),
            {acc_ok, acc_illegal, acc_virt, acc_redirect}, v[7:4]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule